// File: doc/BRIEF.md
# Programmable Memory-Cycle Pattern Sequencer

This block generates external memory control waveforms from a small pattern RAM instead of a fixed state machine. Each RAM word describes one clock of a memory cycle: the chip-select level, whether transfer-acknowledge is raised, whether the pattern ends, whether a bus-monitor timeout may divert execution to an exception pattern, and whether a per-bank disable timer is started at the end of the pattern. Software loads the words through a configuration write port. A client then issues a bank access with a ready/valid handshake, naming the target bank and the pattern start address.

Once a request is accepted the sequencer executes one word per clock. It walks forward through the RAM, wrapping at the top, until it reaches a word marked as last. When a timeout arrives during a word that allows exceptions, execution continues at a shared exception start address. The sequencer touches only the chip-select of the bank being served. It keeps each chip-select at its last programmed level between patterns. Each bank has its own disable timer, which holds off a new access to that bank for a programmed number of clocks. Accesses to other banks are not delayed.

The word layout is 5 bits: bit 0 chip-select active, bit 1 acknowledge, bit 2 last, bit 3 exception enable, bit 4 timer start.

Top module: `cyc_pattern_seq`

## Requirements
- R1: After reset every `cs_n` bit is 1, `ack` is 0, and `req_ready` is 1 for any bank.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The word at `req_start` is executed in the next cycle, and its outputs appear after the following edge. In general, the outputs of the k-th executed word (k from 0) are visible after the (k+1)-th edge following acceptance.
- R3: Without a taken exception, the next word is at the current address plus one, and address 63 is followed by address 0.
- R4: A word with bit 2 (last) set is the final word of the pattern. After the edge that consumes it, the sequencer is idle, and `req_ready` is 1 for any bank whose timer is not running.
- R5: When `bm_timeout` is 1 during a word that has bit 3 set and bit 2 clear, the next word executed is the one at `exc_start`. When bit 2 is set in that word, the pattern ends and the timeout is not taken.
- R6: When `bm_timeout` is 1 during a word whose bit 3 is clear, the timeout has no effect and execution continues at the next address.
- R7: `ack` is 1 for exactly one cycle for each executed word with bit 1 set, and it is 0 otherwise.
- R8: Only the served bank's `cs_n` bit changes. It is driven low for a word with bit 0 set and high for a word with bit 0 clear. The other banks' bits hold their values.
- R9: When a word has both bit 4 and bit 2 set, the served bank's `req_ready` stays 0 for exactly N cycles after the pattern ends, where N is that bank's 4-bit field in `dis_cnt`. N = 0 gives no delay.
- R10: Bit 4 in a word without bit 2 has no effect, so the bank is ready again right after its pattern ends.
- R11: A running disable timer does not affect `req_ready` for any other bank.
- R12: While idle, each `cs_n` bit keeps the level set by the last word executed for that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Pattern RAM write enable |
| cfg_addr | input | 6 | Pattern RAM write address |
| cfg_wdata | input | 5 | Pattern word to write |
| exc_start | input | 6 | Exception pattern start address |
| dis_cnt | input | 16 | Disable period per bank, 4 bits each, bank 0 in the low bits |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | 2 | Bank targeted by the request |
| req_start | input | 6 | Pattern start address for the request |
| bm_timeout | input | 1 | Bus-monitor timeout indication |
| cs_n | output | 4 | Active-low chip-select per bank |
| ack | output | 1 | Transfer acknowledge |

## Verification
After acceptance, the word read from RAM becomes current one edge later, and its chip-select and acknowledge values appear after the next edge. The bench therefore walks its own copy of the pattern RAM one word per clock. It drives `bm_timeout` at the falling edge while a word is current and compares that word's outputs at the falling edge after the next rising edge. The disable window starts at the edge that consumes the last word. `req_ready` is sampled at falling edges 0 through N after that edge and is expected low for the first N samples and high at sample N. The idle hold and the cases where a timeout or timer bit is ignored are checked at the ports over several idle cycles.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef struct packed {
    logic tmr_on;
    logic exc_en;
    logic last;
    logic ack;
    logic cs;
  } word_t;
  localparam int WORD_W = $bits(word_t);
endpackage

// File: rtl/cps_pattern_ram.sv
module cps_pattern_ram
  import cps_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wr_data,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_data
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cps_bank_timers.sv
module cps_bank_timers #(
  parameter int NB = 4,
  parameter int CW = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [BW-1:0] load_bank,
  input  logic [NB*CW-1:0] period,
  output logic [NB-1:0] blocked
);
  for (genvar b = 0; b < NB; b++) begin : g_tmr
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else if (load && load_bank == BW'(b)) begin
        cnt_q <= period[b*CW +: CW];
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
    assign blocked[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/cps_seq_ctrl.sv
module cps_seq_ctrl
  import cps_pkg::*;
#(
  parameter int NB = 4,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [BW-1:0] req_bank,
  input  logic [AW-1:0] req_start,
  output logic          req_ready,
  input  logic [NB-1:0] bank_blocked,
  input  logic [AW-1:0] exc_start,
  input  logic          bm_timeout,
  input  word_t         cur_word,
  output logic [AW-1:0] rd_addr,
  output logic          tmr_load,
  output logic [BW-1:0] tmr_bank,
  output logic [NB-1:0] cs_n_o,
  output logic          ack_o
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t        state_q;
  logic [AW-1:0] pc_q;
  logic [BW-1:0] bank_q;
  logic          running;
  logic          accept;
  logic          take_exc;

  assign running   = (state_q == ST_RUN);
  assign req_ready = !running && !bank_blocked[req_bank];
  assign accept    = req_valid && req_ready;
  assign take_exc  = running && !cur_word.last && cur_word.exc_en && bm_timeout;

  always_comb begin
    if (!running)      rd_addr = req_start;
    else if (take_exc) rd_addr = exc_start;
    else               rd_addr = pc_q + 1'b1;
  end

  assign tmr_load = running && cur_word.last && cur_word.tmr_on;
  assign tmr_bank = bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      bank_q  <= '0;
      cs_n_o  <= '1;
      ack_o   <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        pc_q    <= req_start;
        bank_q  <= req_bank;
      end
      if (running) begin
        cs_n_o[bank_q] <= ~cur_word.cs;
        ack_o          <= cur_word.ack;
        if (cur_word.last) state_q <= ST_IDLE;
        else               pc_q    <= rd_addr;
      end
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    accept |=> running); // R2
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (running && cur_word.last) |=> !running); // R4
  AST_ACK_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(running)); // R7

  for (genvar b = 0; b < NB; b++) begin : g_chk
    AST_OTHER_CS_STABLE: assert property (@(posedge clk) disable iff (rst)
      (running && bank_q != BW'(b)) |=> $stable(cs_n_o[b])); // R8
    AST_IDLE_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
      !running |=> $stable(cs_n_o[b])); // R12
  end
endmodule

// File: rtl/cyc_pattern_seq.sv
module cyc_pattern_seq
  import cps_pkg::*;
#(
  parameter int NB = 4,
  parameter int DEPTH = 64,
  parameter int CW = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic [AW-1:0]    exc_start,
  input  logic [NB*CW-1:0] dis_cnt,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BW-1:0]    req_bank,
  input  logic [AW-1:0]    req_start,
  input  logic             bm_timeout,
  output logic [NB-1:0]    cs_n,
  output logic             ack
);
  word_t         cur_word;
  logic [AW-1:0] rd_addr;
  logic          tmr_load;
  logic [BW-1:0] tmr_bank;
  logic [NB-1:0] blocked;

  cps_pattern_ram #(.DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (word_t'(cfg_wdata)),
    .rd_addr (rd_addr),
    .rd_data (cur_word)
  );

  cps_bank_timers #(.NB(NB), .CW(CW)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .load      (tmr_load),
    .load_bank (tmr_bank),
    .period    (dis_cnt),
    .blocked   (blocked)
  );

  cps_seq_ctrl #(.NB(NB), .DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_bank     (req_bank),
    .req_start    (req_start),
    .req_ready    (req_ready),
    .bank_blocked (blocked),
    .exc_start    (exc_start),
    .bm_timeout   (bm_timeout),
    .cur_word     (cur_word),
    .rd_addr      (rd_addr),
    .tmr_load     (tmr_load),
    .tmr_bank     (tmr_bank),
    .cs_n_o       (cs_n),
    .ack_o        (ack)
  );

  AST_TIMER_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    (tmr_load && dis_cnt[tmr_bank*CW +: CW] != '0)
      |=> !(req_ready && req_bank == $past(tmr_bank))); // R9
endmodule

// File: tb/test_cyc_pattern_seq.sv
module test_cyc_pattern_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [4:0]  cfg_wdata = '0;
  logic [5:0]  exc_start = '0;
  logic [15:0] dis_cnt = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [5:0]  req_start = '0;
  logic        bm_timeout = 1'b0;
  logic [3:0]  cs_n;
  logic        ack;

  int n_chk = 0;
  int n_err = 0;
  logic [4:0] mem [64];
  logic [3:0] exp_csn = 4'hF;

  always #10 clk = ~clk;

  cyc_pattern_seq i_cyc_pattern_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .exc_start(exc_start), .dis_cnt(dis_cnt),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_start(req_start), .bm_timeout(bm_timeout), .cs_n(cs_n), .ack(ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wr(input int a, input logic [4:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = w; mem[a] = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // to_step: -1 no timeout, -2 random timeouts, else step index with timeout
  task automatic run_pat(input int bank, input int start, input int to_step);
    int pc = start;
    int step = 0;
    logic [4:0] cur;
    bit to;
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'(bank); req_start = 6'(start);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      cur = mem[pc];
      to = (to_step == step) || (to_step == -2 && step < 200 && $urandom_range(3) == 0);
      bm_timeout = to;
      @(posedge clk);
      @(negedge clk);
      bm_timeout = 1'b0;
      exp_csn[bank] = ~cur[0];
      if (to) chk(cs_n == exp_csn, (cur[3] && !cur[2]) ? "R5 cs" : "R6 cs", cs_n, exp_csn);
      else    chk(cs_n == exp_csn, "R2 R3 R8 cs", cs_n, exp_csn);
      chk(ack == cur[1], "R7 ack", ack, cur[1]);
      if (cur[2]) break;
      pc = (cur[3] && to) ? int'(exc_start) : (pc + 1) % 64;
      step++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd17));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    dis_cnt = {4'd3, 4'd0, 4'd5, 4'd7};
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
    chk(ack == 1'b0, "R1 ack", ack, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);

    wr(0, 5'h01); wr(1, 5'h03); wr(2, 5'h01); wr(3, 5'h14);
    wr(10, 5'h01); wr(11, 5'h05);
    wr(20, 5'h11); wr(21, 5'h04);
    wr(30, 5'h09); wr(31, 5'h01); wr(32, 5'h04); wr(33, 5'h0C);
    wr(40, 5'h02); wr(41, 5'h04);
    wr(62, 5'h01); wr(63, 5'h01);
    exc_start = 6'd40;

    // R9 / R11 / R4: timer for bank 1, period 5
    run_pat(1, 0, -1);
    req_bank = 2'd2; #1;
    chk(req_ready == 1'b1, "R4 R11 other bank ready", req_ready, 1);
    req_bank = 2'd1; #1;
    for (int m = 0; m < 5; m++) begin
      chk(req_ready == 1'b0, "R9 same bank blocked", req_ready, 0);
      @(posedge clk); @(negedge clk); #1;
    end
    chk(req_ready == 1'b1, "R9 same bank free", req_ready, 1);

    // R12: last word leaves chip-select asserted
    run_pat(2, 10, -1);
    for (int m = 0; m < 3; m++) begin
      @(posedge clk); @(negedge clk);
      chk(cs_n == exp_csn, "R12 idle hold", cs_n, exp_csn);
    end
    run_pat(2, 0, -1);

    // R10: timer bit without last
    run_pat(0, 20, -1);
    req_bank = 2'd0; #1;
    chk(req_ready == 1'b1, "R10 timer ignored", req_ready, 1);

    // R5 / R6: exceptions
    run_pat(0, 30, 0);
    run_pat(0, 30, 1);
    run_pat(0, 33, 0);
    req_bank = 2'd0; #1;
    chk(req_ready == 1'b1, "R5 last wins over exception", req_ready, 1);

    // R3: wrap from 63 to 0
    run_pat(3, 62, -1);

    // random phase
    for (int r = 0; r < 4; r++) begin
      for (int a = 0; a < 64; a++) begin
        logic [4:0] w;
        w = 5'($urandom_range(31));
        w[2] = (a == 63) || ($urandom_range(3) == 0);
        wr(a, w);
      end
      exc_start = 6'($urandom_range(63));
      dis_cnt = 16'($urandom);
      for (int k = 0; k < 12; k++)
        run_pat($urandom_range(3), $urandom_range(63), -2);
    end
    finish_run();
  end
endmodule